// File: doc/BRIEF.md
# Dual GPIO port register bank

This block holds two 8-bit general-purpose I/O ports, A and B, behind a byte-wide register bus made of an address, a write strobe, write data and registered read data. Each port has three read/write registers. The data register holds the output level. The direction register sets each pin as an input or an output. The option register sets each output pin as push-pull or open-drain.

From these registers the block drives a per-pin output enable and output value to the pads. While a pin is an input, its data bit and option bit are exported as a 2-bit configuration code, and the pad decodes that code. Pin levels pass through a two-flop synchroniser before they can be read back.

A read of a data register returns, bit by bit, the latched value for output pins and the synchronised pin level for input pins. Reset puts all pins in input mode.

Top module: `gpio_dual_bank`

## Requirements
- R1: While reset is held, and directly after it, all six registers read 00h. Every pad output enable, pad output value and input configuration bit is 0.
- R2: A write with the strobe high takes effect at the clock edge. The six registers are at these addresses: port A data C0h, port B data C1h, port A direction C4h, port B direction C5h, port A option CCh, port B option CDh. The direction and option registers read back exactly what was written.
- R3: Read data is registered. The address presented before an edge gives bus_rdata after that edge. A data register read returns the latch bit where the direction bit is 1 (output), and the synchronised pin bit where the direction bit is 0 (input).
- R4: A pin level is taken through two flops. The address is held on the port's data register and the pin is an input. If the pin changes before edge k, reads clocked at edges k and k+1 still return the old level. The read clocked at edge k+2 returns the new level.
- R5: Push-pull output (direction 1, option 1): the output enable is 1 and the output value equals the data bit.
- R6: Open-drain output (direction 1, option 0): the output enable is 1 with value 0 when the data bit is 0. The pad is released (enable 0, value 0) when the data bit is 1.
- R7: An input pin (direction 0) has output enable 0 and output value 0, whatever its data and option bits hold.
- R8: For an input pin i, in_cfg bit 2i+1 is its data bit and bit 2i is its option bit. For an output pin both bits are 0.
- R9: A write to any other address changes no register and no output. A read of any other address returns 00h.
- R10: The ports are independent. A write to one port's registers leaves the other port's outputs and read-back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_a | input | 8 | Port A pin levels (asynchronous) |
| pin_b | input | 8 | Port B pin levels (asynchronous) |
| pad_oe_a | output | 8 | Port A per-pin output enable |
| pad_out_a | output | 8 | Port A per-pin output value |
| pad_oe_b | output | 8 | Port B per-pin output enable |
| pad_out_b | output | 8 | Port B per-pin output value |
| in_cfg_a | output | 16 | Port A input configuration codes, 2 bits per pin |
| in_cfg_b | output | 16 | Port B input configuration codes, 2 bits per pin |

## Verification
Some rules are checked on every cycle. Input pins never drive, and an open-drain pin never drives a 1. Output pins export a zero configuration code. Direction writes land on the next edge, unmapped writes leave every register untouched, and unmapped reads return zero. A read of an all-input data register returns the synchroniser's second stage. Only the bench scenarios show the rest: the exact output patterns for mixed push-pull, open-drain and input pins; the two-cycle delay from a pin change to read data; the 2-bit configuration code layout; and the independence of the two ports.

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank #(
  parameter int WIDTH = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] ADR_DR_A  = 8'hC0,
  parameter logic [AW-1:0] ADR_DR_B  = 8'hC1,
  parameter logic [AW-1:0] ADR_DIR_A = 8'hC4,
  parameter logic [AW-1:0] ADR_DIR_B = 8'hC5,
  parameter logic [AW-1:0] ADR_OPT_A = 8'hCC,
  parameter logic [AW-1:0] ADR_OPT_B = 8'hCD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic [WIDTH-1:0]   bus_wdata,
  output logic [WIDTH-1:0]   bus_rdata,
  input  logic [WIDTH-1:0]   pin_a,
  input  logic [WIDTH-1:0]   pin_b,
  output logic [WIDTH-1:0]   pad_oe_a,
  output logic [WIDTH-1:0]   pad_out_a,
  output logic [WIDTH-1:0]   pad_oe_b,
  output logic [WIDTH-1:0]   pad_out_b,
  output logic [2*WIDTH-1:0] in_cfg_a,
  output logic [2*WIDTH-1:0] in_cfg_b
);
  localparam int NP = 2;
  localparam logic [AW-1:0] DR_ADR  [NP] = '{ADR_DR_A,  ADR_DR_B};
  localparam logic [AW-1:0] DIR_ADR [NP] = '{ADR_DIR_A, ADR_DIR_B};
  localparam logic [AW-1:0] OPT_ADR [NP] = '{ADR_OPT_A, ADR_OPT_B};

  logic [WIDTH-1:0]   dat [NP];
  logic [WIDTH-1:0]   dir [NP];
  logic [WIDTH-1:0]   opt [NP];
  logic [WIDTH-1:0]   sy1 [NP];
  logic [WIDTH-1:0]   sy2 [NP];
  logic [WIDTH-1:0]   pin [NP];
  logic [WIDTH-1:0]   oe  [NP];
  logic [WIDTH-1:0]   dout[NP];
  logic [2*WIDTH-1:0] cfg [NP];
  logic [WIDTH-1:0]   rd_next;
  logic               mapped;

  assign pin[0] = pin_a;
  assign pin[1] = pin_b;

  for (genvar p = 0; p < NP; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dat[p] <= '0;
        dir[p] <= '0;
        opt[p] <= '0;
        sy1[p] <= '0;
        sy2[p] <= '0;
      end else begin
        sy1[p] <= pin[p];
        sy2[p] <= sy1[p];
        if (bus_wr && bus_addr == DR_ADR[p])  dat[p] <= bus_wdata;
        if (bus_wr && bus_addr == DIR_ADR[p]) dir[p] <= bus_wdata;
        if (bus_wr && bus_addr == OPT_ADR[p]) opt[p] <= bus_wdata;
      end
    end

    assign oe[p]   = dir[p] & (opt[p] | ~dat[p]);
    assign dout[p] = dir[p] & opt[p] & dat[p];

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign cfg[p][2*i+1] = ~dir[p][i] & dat[p][i];
      assign cfg[p][2*i]   = ~dir[p][i] & opt[p][i];

      assert_cfg_output_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dir[p][i] |-> cfg[p][2*i+1 -: 2] == 2'b00);
    end

    assert_input_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((oe[p] | dout[p]) & ~dir[p]) == '0);
    assert_od_never_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dout[p] & ~opt[p]) == '0 && (dout[p] & ~oe[p]) == '0);
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == DIR_ADR[p] |=> dir[p] == $past(bus_wdata));
    assert_unmapped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !mapped |=> $stable(dat[p]) && $stable(dir[p]) && $stable(opt[p]));
    assert_sync_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == DR_ADR[p] && dir[p] == '0 |=> bus_rdata == $past(sy2[p]));
  end

  always_comb begin
    rd_next = '0;
    mapped  = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (bus_addr == DR_ADR[p]) begin
        rd_next = (dat[p] & dir[p]) | (sy2[p] & ~dir[p]);
        mapped  = 1'b1;
      end
      if (bus_addr == DIR_ADR[p]) begin
        rd_next = dir[p];
        mapped  = 1'b1;
      end
      if (bus_addr == OPT_ADR[p]) begin
        rd_next = opt[p];
        mapped  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

  assign pad_oe_a  = oe[0];
  assign pad_out_a = dout[0];
  assign pad_oe_b  = oe[1];
  assign pad_out_b = dout[1];
  assign in_cfg_a  = cfg[0];
  assign in_cfg_b  = cfg[1];

  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |=> bus_rdata == '0);
endmodule

// File: tb/tb_gpio_dual_bank.sv
module tb_gpio_dual_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_a = 8'h5A, pin_b = 8'h3C;
  logic [7:0]  pad_oe_a, pad_out_a, pad_oe_b, pad_out_b;
  logic [15:0] in_cfg_a, in_cfg_b;

  int checks = 0, errors = 0;
  logic rd_flag = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  gpio_dual_bank dut (.*);

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    rd_flag = 0; bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    bus_addr = a; rd_flag = 1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rd_flag = 0;
    end
  endtask

  task automatic pads(string tag, logic [7:0] oa, logic [7:0] va, logic [7:0] ob, logic [7:0] vb,
                      logic [15:0] ca, logic [15:0] cb);
    chk({tag, " oe_a"}, pad_oe_a, oa);
    chk({tag, " out_a"}, pad_out_a, va);
    chk({tag, " oe_b"}, pad_oe_b, ob);
    chk({tag, " out_b"}, pad_out_b, vb);
    chk({tag, " cfg_a"}, in_cfg_a, ca);
    chk({tag, " cfg_b"}, in_cfg_b, cb);
  endtask

  // monitor: pops expected read data one cycle after each address is presented
  initial begin
    forever begin
      @(posedge clk);
      if (rd_flag) begin
        #1;
        if (exp_q.size() == 0) begin
          chk("scoreboard underflow", 0, 1);
        end else begin
          chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk("watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    pads("R1 in reset", 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000);
    chk("R1 rdata in reset", bus_rdata, 8'h00);
    rst_n = 1;
    idle(3);
    rd(8'hC4, 8'h00, "R1 dir A");
    rd(8'hCD, 8'h00, "R1 opt B");
    rd(8'hC0, 8'h5A, "R3 data A all inputs");
    rd(8'hC1, 8'h3C, "R3 data B all inputs");
    idle(1);

    wr(8'hC4, 8'hF0);
    wr(8'hCC, 8'hCC);
    wr(8'hC5, 8'h0F);
    wr(8'hCD, 8'h55);
    rd(8'hC4, 8'hF0, "R2 dir A");
    rd(8'hCC, 8'hCC, "R2 opt A");
    rd(8'hC5, 8'h0F, "R2 dir B");
    rd(8'hCD, 8'h55, "R2 opt B");
    idle(1);

    wr(8'hC0, 8'hA6);
    pads("R5 R6 R7 R8 mixed A", 8'hD0, 8'h80, 8'h0F, 8'h00, 16'h0078, 16'h1100);
    rd(8'hC0, 8'hAA, "R3 data A mixed");
    idle(1);

    wr(8'hC1, 8'hFF);
    pads("R10 R6 B write", 8'hD0, 8'h80, 8'h05, 8'h05, 16'h0078, 16'hBB00);
    rd(8'hC1, 8'h3F, "R3 data B mixed");
    rd(8'hC0, 8'hAA, "R10 data A unchanged");
    idle(1);

    wr(8'hC2, 8'hFF);
    wr(8'hFF, 8'h00);
    wr(8'h00, 8'h12);
    pads("R9 after unmapped writes", 8'hD0, 8'h80, 8'h05, 8'h05, 16'h0078, 16'hBB00);
    rd(8'hC4, 8'hF0, "R9 dir A kept");
    rd(8'hCD, 8'h55, "R9 opt B kept");
    rd(8'hC2, 8'h00, "R9 unmapped read C2");
    rd(8'hFF, 8'h00, "R9 unmapped read FF");
    idle(1);

    rd(8'hC0, 8'hAA, "R4 edge k old");
    pin_a = 8'h53;
    rd(8'hC0, 8'hAA, "R4 edge k+1 old");
    rd(8'hC0, 8'hA3, "R4 edge k+2 new");
    idle(1);

    wr(8'hC4, 8'h00);
    pads("R7 R8 all inputs A", 8'h00, 8'h00, 8'h05, 8'h05, 16'hD878, 16'hBB00);
    rd(8'hC0, 8'h53, "R3 data A back to pins");
    idle(1);

    wr(8'hC4, 8'hFF);
    wr(8'hCC, 8'hFF);
    pads("R5 push-pull A", 8'hFF, 8'hA6, 8'h05, 8'h05, 16'h0000, 16'hBB00);
    wr(8'hCC, 8'h00);
    pads("R6 open-drain A", 8'h59, 8'h00, 8'h05, 8'h05, 16'h0000, 16'hBB00);
    rd(8'hC0, 8'hA6, "R3 data A all outputs");
    idle(2);

    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule